// File: doc/BRIEF.md
# Program-Counter Function Profiler

This block turns a stream of sampled program-counter values into a compact log of function entries. A management controller first fills an on-chip table with the start addresses of every function and interrupt handler, in ascending order, and states how many entries are valid. The block then looks up each sample and finds the table entry with the largest start address that does not exceed the sample. Only changes of function are written out, so a long stay inside one routine costs a single record.

The lookup is a binary search spread over a pipeline. Each stage makes one comparison against its own small bank of the table. A new sample can enter on every 48 MHz fabric clock, which is well above the rate at which the debug port can supply samples (one every seven target-CPU cycles). A change filter follows the search. After it sits a first-word-fall-through FIFO that the management controller drains at its own pace. Each record holds a hit flag, the function index and a 16-bit timestamp. The timestamp counts fabric cycles since the profiling session started.

A three-state controller governs the block. In LOAD the table may be written and samples are ignored. In RUN samples are accepted and table writes are ignored. In DRAIN samples are ignored and the search pipeline finishes the lookups already in flight, then the controller returns to LOAD. Transitions: LOAD to RUN when `run_req` rises; RUN to DRAIN when `run_req` falls; DRAIN to LOAD once the search pipeline holds no valid sample.

Top module: `pcprof_top`

## Requirements
- R1: After reset the controller is in LOAD: `load_ready` is 1, `rec_valid` is 0 and `fifo_overflow` is 0.
- R2: While `load_ready` is 1, a cycle with `tbl_we` high stores `tbl_data` as table entry `tbl_addr`. `tbl_count` is captured on the LOAD to RUN transition. Table writes made in RUN or DRAIN have no effect.
- R3: For a table sorted ascending over its first `tbl_count` entries, a sample resolves to `rec_hit`=1 and `rec_index` = the greatest i < `tbl_count` whose entry is less than or equal to the sample.
- R4: A sample below entry 0, or any sample when `tbl_count` is 0, resolves to `rec_hit`=0 with `rec_index` all ones (8'hFF).
- R5: A resolved sample is recorded only when its pair (hit, index) differs from that of the previous resolved sample of the same session. The first resolved sample of a session is always recorded.
- R6: One sample per cycle is accepted in RUN. With the FIFO empty, the record for a sample taken at clock edge E is visible on `rec_valid` right after edge E+10.
- R7: `rec_stamp` is the number of RUN cycles that passed before the sample was taken: 0 for a sample taken in the first RUN cycle. It wraps at 16 bits.
- R8: `pc_valid` has no effect outside RUN.
- R9: The FIFO presents its oldest record while `rec_valid` is 1. `rec_pop` removes that record, records leave in arrival order, and a pop while the FIFO is empty is ignored.
- R10: A record arriving while the FIFO holds 16 records is dropped and sets `fifo_overflow`. The flag stays set until the next LOAD to RUN transition clears it.
- R11: LOAD goes to RUN on `run_req`=1, RUN goes to DRAIN on `run_req`=0, and DRAIN goes to LOAD once no lookup is in flight. Lookups started in RUN still deliver their records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_req | input | 1 | High to start and hold a profiling session |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 8 | Table entry being written |
| tbl_data | input | 16 | Start address to store |
| tbl_count | input | 9 | Number of valid table entries (0 to 256) |
| pc_valid | input | 1 | A program-counter sample is present |
| pc_value | input | 16 | Program-counter sample |
| rec_pop | input | 1 | Remove the head record |
| rec_valid | output | 1 | FIFO holds at least one record |
| rec_hit | output | 1 | Head record resolved to a table entry |
| rec_index | output | 8 | Head record function index (all ones when unknown) |
| rec_stamp | output | 16 | Head record timestamp |
| fifo_overflow | output | 1 | Sticky: a record was dropped for lack of space |
| load_ready | output | 1 | Controller is in LOAD |

## Verification
The bench drives inputs and reads outputs on falling edges, so each registered result is read half a cycle after the rising edge that produced it. Records come out ten rising edges after the sample is taken. The latency test therefore checks that `rec_valid` is still low after edge E+9 and high after edge E+10. All other sessions wait for `load_ready` to return before draining the FIFO, and then compare every record, including its stamp, against a linear-scan model and a model of the change filter. Effects that should be ignored (samples outside RUN, table writes in RUN, pops on an empty FIFO) are checked through the records that later appear, or fail to appear, at the output.

// File: rtl/pcprof_pkg.sv
package pcprof_pkg;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } prof_state_e;

endpackage

// File: rtl/pcprof_search.sv
module pcprof_search #(
    parameter int AW = 16,
    parameter int IW = 8,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_addr,
    input  logic [AW-1:0] wr_data,
    input  logic [IW:0]   entry_cnt,
    input  logic          in_vld,
    input  logic [AW-1:0] in_pc,
    input  logic [TW-1:0] in_ts,
    output logic          out_vld,
    output logic          out_hit,
    output logic [IW-1:0] out_idx,
    output logic [TW-1:0] out_ts,
    output logic          busy
);

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] pc;
        logic [TW-1:0] ts;
        logic [IW-1:0] idx;
    } probe_t;

    probe_t      link [IW+1];
    logic [IW:0] vld_vec;
    probe_t      in_q;

    // poll stage: register the incoming sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q <= '0;
        end else begin
            in_q.vld <= in_vld;
            in_q.pc  <= in_pc;
            in_q.ts  <= in_ts;
            in_q.idx <= '0;
        end
    end

    assign link[0] = in_q;

    // one comparison per stage; stage s decides index bit IW-1-s
    for (genvar s = 0; s < IW; s++) begin : g_lvl
        localparam int            B    = IW - 1 - s;
        localparam logic [IW-1:0] STEP = IW'(1) << B;
        localparam logic [IW-1:0] LOW  = STEP - IW'(1);

        logic [AW-1:0] probe_val;
        logic          wr_here;
        logic [IW-1:0] cand;
        logic          take;
        probe_t        q;

        // this bank owns the entries whose lowest set bit is bit B
        assign wr_here = wr_en && ((wr_addr & STEP) != '0) && ((wr_addr & LOW) == '0);

        if (s == 0) begin : g_root
            logic [AW-1:0] key;
            always_ff @(posedge clk) begin
                if (wr_here) key <= wr_data;
            end
            assign probe_val = key;
        end else begin : g_bank
            logic [AW-1:0] bank [2**s];
            always_ff @(posedge clk) begin
                if (wr_here) bank[wr_addr[IW-1:B+1]] <= wr_data;
            end
            assign probe_val = bank[link[s].idx[IW-1:B+1]];
        end

        assign cand = link[s].idx | STEP;
        assign take = ({1'b0, cand} < entry_cnt) && (probe_val <= link[s].pc);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else begin
                q <= link[s];
                if (take) q.idx <= cand;
            end
        end

        assign link[s+1]  = q;
        assign vld_vec[s] = link[s].vld;
    end

    assign vld_vec[IW] = link[IW].vld;

    // final stage: entry 0 decides between index 0 and unknown
    logic [AW-1:0] base_key;
    logic          last_hit;

    always_ff @(posedge clk) begin
        if (wr_en && (wr_addr == '0)) base_key <= wr_data;
    end

    assign last_hit = (link[IW].idx != '0) ||
                      ((entry_cnt != '0) && (base_key <= link[IW].pc));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_hit <= 1'b0;
            out_idx <= '0;
            out_ts  <= '0;
        end else begin
            out_vld <= link[IW].vld;
            out_hit <= last_hit;
            out_idx <= last_hit ? link[IW].idx : '1;
            out_ts  <= link[IW].ts;
        end
    end

    assign busy = (|vld_vec) || out_vld;

endmodule

// File: rtl/pcprof_filter.sv
module pcprof_filter #(
    parameter int IW = 8,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          in_vld,
    input  logic          in_hit,
    input  logic [IW-1:0] in_idx,
    input  logic [TW-1:0] in_ts,
    output logic          push,
    output logic          push_hit,
    output logic [IW-1:0] push_idx,
    output logic [TW-1:0] push_ts
);

    logic          have_prev;
    logic          prev_hit;
    logic [IW-1:0] prev_idx;
    logic          changed;

    assign changed  = !have_prev || (prev_hit != in_hit) || (prev_idx != in_idx);
    assign push     = in_vld && changed;
    assign push_hit = in_hit;
    assign push_idx = in_idx;
    assign push_ts  = in_ts;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_prev <= 1'b0;
            prev_hit  <= 1'b0;
            prev_idx  <= '0;
        end else if (clear) begin
            have_prev <= 1'b0;
        end else if (in_vld) begin
            have_prev <= 1'b1;
            prev_hit  <= in_hit;
            prev_idx  <= in_idx;
        end
    end

endmodule

// File: rtl/pcprof_fifo.sv
module pcprof_fifo #(
    parameter int W   = 25,
    parameter int DL2 = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    input  logic         clr_ovf,
    output logic [W-1:0] head,
    output logic         nonempty,
    output logic         ovf
);

    localparam int DEPTH = 2**DL2;

    logic [W-1:0] mem [DEPTH];
    logic [DL2:0] wr_p, rd_p;
    logic         full, empty, do_push, do_pop;

    assign empty   = (wr_p == rd_p);
    assign full    = (wr_p[DL2] != rd_p[DL2]) && (wr_p[DL2-1:0] == rd_p[DL2-1:0]);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_p[DL2-1:0]] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_p <= '0;
            rd_p <= '0;
            ovf  <= 1'b0;
        end else begin
            if (do_push) wr_p <= wr_p + 1'b1;
            if (do_pop)  rd_p <= rd_p + 1'b1;
            if (clr_ovf)              ovf <= 1'b0;
            else if (push && full)    ovf <= 1'b1;
        end
    end

    assign head     = mem[rd_p[DL2-1:0]];
    assign nonempty = !empty;

endmodule

// File: rtl/pcprof_top.sv
module pcprof_top
    import pcprof_pkg::*;
#(
    parameter int AW       = 16,
    parameter int IW       = 8,
    parameter int TW       = 16,
    parameter int FIFO_DL2 = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_req,
    input  logic          tbl_we,
    input  logic [IW-1:0] tbl_addr,
    input  logic [AW-1:0] tbl_data,
    input  logic [IW:0]   tbl_count,
    input  logic          pc_valid,
    input  logic [AW-1:0] pc_value,
    input  logic          rec_pop,
    output logic          rec_valid,
    output logic          rec_hit,
    output logic [IW-1:0] rec_index,
    output logic [TW-1:0] rec_stamp,
    output logic          fifo_overflow,
    output logic          load_ready
);

    localparam int REC_W = 1 + IW + TW;

    prof_state_e st_q, st_d;
    logic        load_win, sample_win, session_go;
    logic        search_busy;
    logic [IW:0] cnt_q;
    logic [TW-1:0] ts_q;

    logic          s_vld, s_hit;
    logic [IW-1:0] s_idx;
    logic [TW-1:0] s_ts;
    logic          f_push, f_hit;
    logic [IW-1:0] f_idx;
    logic [TW-1:0] f_ts;
    logic [REC_W-1:0] head;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_LOAD;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_LOAD:  if (run_req)      st_d = ST_RUN;
            ST_RUN:   if (!run_req)     st_d = ST_DRAIN;
            ST_DRAIN: if (!search_busy) st_d = ST_LOAD;
            default:                    st_d = ST_LOAD;
        endcase
    end

    // outputs of the controller
    always_comb begin
        load_win   = 1'b0;
        sample_win = 1'b0;
        session_go = 1'b0;
        unique case (st_q)
            ST_LOAD: begin
                load_win   = 1'b1;
                session_go = run_req;
            end
            ST_RUN:   sample_win = 1'b1;
            ST_DRAIN: ;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ts_q  <= '0;
        end else begin
            if (session_go) begin
                cnt_q <= tbl_count;
                ts_q  <= '0;
            end else if (sample_win) begin
                ts_q <= ts_q + 1'b1;
            end
        end
    end

    pcprof_search #(.AW(AW), .IW(IW), .TW(TW)) u_search (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (tbl_we && load_win),
        .wr_addr   (tbl_addr),
        .wr_data   (tbl_data),
        .entry_cnt (cnt_q),
        .in_vld    (pc_valid && sample_win),
        .in_pc     (pc_value),
        .in_ts     (ts_q),
        .out_vld   (s_vld),
        .out_hit   (s_hit),
        .out_idx   (s_idx),
        .out_ts    (s_ts),
        .busy      (search_busy)
    );

    pcprof_filter #(.IW(IW), .TW(TW)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (session_go),
        .in_vld   (s_vld),
        .in_hit   (s_hit),
        .in_idx   (s_idx),
        .in_ts    (s_ts),
        .push     (f_push),
        .push_hit (f_hit),
        .push_idx (f_idx),
        .push_ts  (f_ts)
    );

    pcprof_fifo #(.W(REC_W), .DL2(FIFO_DL2)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (f_push),
        .push_data ({f_hit, f_idx, f_ts}),
        .pop       (rec_pop),
        .clr_ovf   (session_go),
        .head      (head),
        .nonempty  (rec_valid),
        .ovf       (fifo_overflow)
    );

    assign rec_hit    = head[REC_W-1];
    assign rec_index  = head[REC_W-2:TW];
    assign rec_stamp  = head[TW-1:0];
    assign load_ready = (st_q == ST_LOAD);

endmodule

// File: rtl/pcprof_checker.sv
module pcprof_checker
    import pcprof_pkg::*;
#(
    parameter int IW = 8,
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    st,
    input logic          run_req,
    input logic          busy,
    input logic          rec_valid,
    input logic          rec_pop,
    input logic          rec_hit,
    input logic [IW-1:0] rec_index,
    input logic [TW-1:0] rec_stamp,
    input logic          fifo_overflow
);

    AST_UNKNOWN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_hit) |-> (rec_index == '1)); // R4

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_overflow && !(st == ST_LOAD && run_req)) |=> fifo_overflow); // R10

    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_pop) |=> (rec_valid && $stable({rec_hit, rec_index, rec_stamp}))); // R9

    AST_RUN_TO_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && !run_req) |=> (st == ST_DRAIN)); // R11

    AST_DRAIN_TO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DRAIN && !busy) |=> (st == ST_LOAD)); // R11

    AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOAD) |-> !busy); // R11

endmodule

bind pcprof_top pcprof_checker #(.IW(IW), .TW(TW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .st            (st_q),
    .run_req       (run_req),
    .busy          (search_busy),
    .rec_valid     (rec_valid),
    .rec_pop       (rec_pop),
    .rec_hit       (rec_hit),
    .rec_index     (rec_index),
    .rec_stamp     (rec_stamp),
    .fifo_overflow (fifo_overflow)
);

// File: tb/pcprof_top_bench.sv
module pcprof_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 16;
    localparam int IW    = 8;
    localparam int TW    = 16;
    localparam int FDEPTH = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_req = 1'b0;
    logic          tbl_we = 1'b0;
    logic [IW-1:0] tbl_addr = '0;
    logic [AW-1:0] tbl_data = '0;
    logic [IW:0]   tbl_count = '0;
    logic          pc_valid = 1'b0;
    logic [AW-1:0] pc_value = '0;
    logic          rec_pop = 1'b0;
    logic          rec_valid, rec_hit, fifo_overflow, load_ready;
    logic [IW-1:0] rec_index;
    logic [TW-1:0] rec_stamp;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    logic [AW-1:0] model_tbl [256];
    int            model_cnt = 0;
    logic [AW-1:0] stim [64];
    int            stim_n = 0;
    bit            poke_in_run = 1'b0;
    logic [24:0]   exp_q [$];
    bit            exp_ovf = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcprof_top u_pcprof_top (
        .clk(clk), .rst_n(rst_n), .run_req(run_req),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data), .tbl_count(tbl_count),
        .pc_valid(pc_valid), .pc_value(pc_value), .rec_pop(rec_pop),
        .rec_valid(rec_valid), .rec_hit(rec_hit), .rec_index(rec_index),
        .rec_stamp(rec_stamp), .fifo_overflow(fifo_overflow), .load_ready(load_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] ref_lookup(input logic [AW-1:0] pc);
        for (int i = model_cnt - 1; i >= 0; i--) begin
            if (model_tbl[i] <= pc) return {1'b1, 8'(i)};
        end
        return {1'b0, 8'hFF};
    endfunction

    task automatic write_entry(input int idx, input logic [AW-1:0] val);
        tbl_we   = 1'b1;
        tbl_addr = 8'(idx);
        tbl_data = val;
        model_tbl[idx] = val;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic load_linear(input int n, input int base, input int step);
        for (int i = 0; i < n; i++) write_entry(i, 16'(base + i * step));
        tbl_count = 9'(n);
    endtask

    task automatic wait_load;
        for (int i = 0; i < 50 && !load_ready; i++) @(negedge clk);
        chk("R11 return to LOAD", 32'(load_ready), 1);
    endtask

    task automatic drain_check(input string req);
        chk({req, " R10 overflow flag"}, 32'(fifo_overflow), 32'(exp_ovf));
        foreach (exp_q[k]) begin
            chk({req, " R9 record present"}, 32'(rec_valid), 1);
            chk({req, " R3 hit/index"}, 32'({rec_hit, rec_index}), 32'(exp_q[k][24:16]));
            chk({req, " R7 stamp"}, 32'(rec_stamp), 32'(exp_q[k][15:0]));
            rec_pop = 1'b1;
            @(negedge clk);
            rec_pop = 1'b0;
        end
        chk({req, " R9 fifo empty after drain"}, 32'(rec_valid), 0);
        exp_q.delete();
    endtask

    // runs one session over stim[0..stim_n-1], one sample per cycle
    task automatic run_session(input string req);
        bit          have_prev = 1'b0;
        logic [8:0]  prev_key = '0;
        logic [8:0]  key;
        exp_q.delete();
        exp_ovf   = 1'b0;
        model_cnt = int'(tbl_count);
        run_req = 1'b1;
        @(negedge clk);
        for (int c = 0; c < stim_n; c++) begin
            if (poke_in_run && c == 0) begin
                tbl_we = 1'b1; tbl_addr = '0; tbl_data = 16'hFFFF;
            end else begin
                tbl_we = 1'b0;
            end
            pc_valid = 1'b1;
            pc_value = stim[c];
            key = ref_lookup(stim[c]);
            if (!have_prev || key != prev_key) begin
                if (exp_q.size() < FDEPTH) exp_q.push_back({key, 16'(c)});
                else                       exp_ovf = 1'b1;
            end
            have_prev = 1'b1;
            prev_key  = key;
            @(negedge clk);
        end
        tbl_we   = 1'b0;
        pc_valid = 1'b0;
        run_req  = 1'b0;
        wait_load();
        drain_check(req);
    endtask

    task automatic t_reset;
        chk("R1 load_ready", 32'(load_ready), 1);
        chk("R1 rec_valid", 32'(rec_valid), 0);
        chk("R1 overflow", 32'(fifo_overflow), 0);
    endtask

    task automatic t_basic;
        load_linear(20, 16'h1000, 16'h0100);
        stim[0] = 16'h0FFF; stim[1] = 16'h1000; stim[2] = 16'h10FF; stim[3] = 16'h1100;
        stim[4] = 16'h2300; stim[5] = 16'hFFFF; stim[6] = 16'h1A80; stim[7] = 16'h0000;
        stim[8] = 16'h1A80; stim[9] = 16'h1AFF;
        stim_n = 10;
        run_session("R3 R4 R5 R6 basic");
    endtask

    task automatic t_latency;
        run_req = 1'b1;
        @(negedge clk);
        pc_valid = 1'b1;
        pc_value = 16'h1234;
        @(negedge clk);
        pc_valid = 1'b0;
        for (int n = 2; n <= 11; n++) begin
            @(negedge clk);
            if (n == 10) chk("R6 no record after 9 edges", 32'(rec_valid), 0);
            if (n == 11) chk("R6 record after 10 edges", 32'(rec_valid), 1);
        end
        run_req = 1'b0;
        wait_load();
        exp_ovf = 1'b0;
        exp_q.push_back({1'b1, 8'd2, 16'd0});
        drain_check("R6 latency");
    endtask

    task automatic t_ignore;
        for (int i = 0; i < 5; i++) begin
            pc_valid = 1'b1;
            pc_value = 16'h1500;
            @(negedge clk);
        end
        pc_valid = 1'b0;
        repeat (14) @(negedge clk);
        chk("R8 samples in LOAD ignored", 32'(rec_valid), 0);
        poke_in_run = 1'b1;
        stim[0] = 16'h1000; stim[1] = 16'h0FFF; stim[2] = 16'h1000;
        stim_n = 3;
        run_session("R2 write in RUN ignored");
        poke_in_run = 1'b0;
    endtask

    task automatic t_edges;
        tbl_count = '0;
        stim[0] = 16'h0000; stim[1] = 16'h8000; stim[2] = 16'hFFFF;
        stim_n = 3;
        run_session("R4 empty table");
        load_linear(256, 0, 16'h0100);
        stim[0] = 16'hFFFF; stim[1] = 16'h0000; stim[2] = 16'h7F80; stim[3] = 16'h8000;
        stim[4] = 16'h80FF; stim[5] = 16'h0100; stim[6] = 16'h00FF; stim[7] = 16'hFE01;
        stim_n = 8;
        run_session("R3 full table");
    endtask

    task automatic t_overflow;
        load_linear(20, 16'h1000, 16'h0100);
        for (int i = 0; i < 40; i++) stim[i] = (i % 2 == 0) ? 16'h1000 : 16'h1100;
        stim_n = 40;
        run_session("R10 overflow");
    endtask

    task automatic t_pop_empty;
        chk("R9 empty before pop", 32'(rec_valid), 0);
        rec_pop = 1'b1;
        @(negedge clk);
        rec_pop = 1'b0;
        stim[0] = 16'h1500;
        stim_n = 1;
        run_session("R9 pop on empty ignored, R10 flag cleared");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_latency();
        t_ignore();
        t_edges();
        t_overflow();
        t_pop_empty();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL R11 watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule